// File: doc/BRIEF.md
# Queued Configuration DMA Controller

This block is a register-programmed word mover for loading configuration data. Software stages a source address, a destination address and two word counts in four registers. Writing the destination word count commits all four values as one command into a four-entry queue. A sequencer takes commands from the queue one at a time. For each word it fetches from a simple memory read port, then delivers the word either to a configuration sink port or to a memory write port.

A destination address of all ones selects the configuration sink. Any other address, or a set loopback control bit, sends the words to memory instead. A quarter-rate control bit spaces out deliveries to the sink. Completion and every error cause latch into separate sticky status bits, which are cleared by writing one. An interrupt output reflects the status bits that a mask register enables.

Top module: `cfg_dma_top`

## Requirements
- R1: Writing the source address (index 4), destination address (index 5) or source count (index 6) queues nothing. Writing the destination count (index 7) pushes all four values as one command, and execution follows without any further write.
- R2: The queue holds 4 commands. Status register (index 1) bit 0 is full, bit 1 is empty and bit 2 is busy. A commit while the queue is full is dropped and sets status bit 6 (queue overflow).
- R3: With destination 0xFFFF_FFFF and loopback clear, the words read from source, source+4, source+8 and so on appear in order on the sink port. A word on the sink is held stable until it is accepted.
- R4: With any other destination and loopback clear, word k is written to the memory write port at destination+4k.
- R5: With loopback set (control register index 0, bit 0), words go to the memory write port even when the destination is all ones, and the sink port stays idle.
- R6: With quarter rate set (control bit 1), two accepted sink words are at least 4 cycles apart. With it clear and the sink always ready, they are 3 cycles apart.
- R7: When the last word of a command is delivered, status bit 0 (done) is set.
- R8: A sink command whose source and destination counts differ is not executed and sets status bit 7 (length error).
- R9: A command with a zero count, or a memory-bound command with unequal counts, is not executed and sets status bit 5 (command error).
- R10: A read response flagged as an error sets status bit 3. A read with no response within 16 cycles sets bit 2. Both abort the command without setting done.
- R11: A write accepted with its error flag set sets status bit 1 and aborts the command without setting done.
- R12: A read response arriving while no read is outstanding sets status bit 4 (receive overflow).
- R13: The interrupt status register is index 2. Writing one to a bit clears it, and writing zero has no effect. A hardware set in the same cycle as a clear wins.
- R14: irq_o is high exactly when some status bit is set whose enable bit in the mask register (index 3) is also set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word index |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i |
| irq_o | output | 1 | Masked interrupt |
| mrd_req_o | output | 1 | Memory read request |
| mrd_addr_o | output | 32 | Memory read byte address |
| mrd_gnt_i | input | 1 | Read request accepted |
| mrd_rvalid_i | input | 1 | Read response valid |
| mrd_rdata_i | input | 32 | Read response data |
| mrd_err_i | input | 1 | Read response error |
| mwr_valid_o | output | 1 | Memory write valid |
| mwr_addr_o | output | 32 | Memory write byte address |
| mwr_data_o | output | 32 | Memory write data |
| mwr_ready_i | input | 1 | Memory write accepted |
| mwr_err_i | input | 1 | Write error, sampled on acceptance |
| cfg_valid_o | output | 1 | Sink word valid |
| cfg_data_o | output | 32 | Sink word |
| cfg_ready_i | input | 1 | Sink ready |

## Verification
The delivery of a command's last word can coincide with a software write-one-to-clear of the done bit. To provoke this, the bench first leaves done set from an earlier command. It then stalls a one-word sink command with the sink not ready. On a single clock edge it raises sink ready and issues the clear write. Reading the status register afterwards must show done still set, and a later clear with no completion must take effect.

// File: rtl/cfg_dma_pkg.sv
package cfg_dma_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned REG_AW = 3;
  localparam int unsigned NUM_EV = 8;

  localparam logic [REG_AW-1:0] RA_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] RA_STAT = 3'd1;
  localparam logic [REG_AW-1:0] RA_ISTS = 3'd2;
  localparam logic [REG_AW-1:0] RA_IMSK = 3'd3;
  localparam logic [REG_AW-1:0] RA_SRC  = 3'd4;
  localparam logic [REG_AW-1:0] RA_DST  = 3'd5;
  localparam logic [REG_AW-1:0] RA_SLEN = 3'd6;
  localparam logic [REG_AW-1:0] RA_DLEN = 3'd7;

  localparam int unsigned EV_DONE  = 0;
  localparam int unsigned EV_WERR  = 1;
  localparam int unsigned EV_RTO   = 2;
  localparam int unsigned EV_RERR  = 3;
  localparam int unsigned EV_RXOV  = 4;
  localparam int unsigned EV_CMDE  = 5;
  localparam int unsigned EV_QOV   = 6;
  localparam int unsigned EV_LENE  = 7;

  localparam logic [WORD_W-1:0] SINK_ADDR = '1;

  typedef struct packed {
    logic [WORD_W-1:0] src;
    logic [WORD_W-1:0] dst;
    logic [WORD_W-1:0] slen;
    logic [WORD_W-1:0] dlen;
  } dma_cmd_t;

  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_XFER} seq_st_e;
endpackage

// File: rtl/cfg_dma_regs.sv
module cfg_dma_regs
  import cfg_dma_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [WORD_W-1:0] wdata_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              loop_o,
  output logic              qrate_o,
  output logic              push_o,
  output dma_cmd_t          push_cmd_o,
  input  logic              q_full_i,
  input  logic              q_empty_i,
  input  logic              busy_i,
  input  logic [NUM_EV-1:0] evt_i,
  output logic [NUM_EV-1:0] sts_o,
  output logic              irq_o
);
  logic [1:0]        ctrl_q;
  logic [NUM_EV-1:0] msk_q, sts_q, clr;
  logic [WORD_W-1:0] src_q, dst_q, slen_q;

  assign clr = (we_i && addr_i == RA_ISTS) ? wdata_i[NUM_EV-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      msk_q  <= '0;
      sts_q  <= '0;
      src_q  <= '0;
      dst_q  <= '0;
      slen_q <= '0;
    end else begin
      // hardware set takes priority over a same-cycle clear
      sts_q <= (sts_q & ~clr) | evt_i;
      if (we_i) begin
        case (addr_i)
          RA_CTRL: ctrl_q <= wdata_i[1:0];
          RA_IMSK: msk_q  <= wdata_i[NUM_EV-1:0];
          RA_SRC:  src_q  <= wdata_i;
          RA_DST:  dst_q  <= wdata_i;
          RA_SLEN: slen_q <= wdata_i;
          default: ;
        endcase
      end
    end
  end

  assign loop_o     = ctrl_q[0];
  assign qrate_o    = ctrl_q[1];
  assign push_o     = we_i && (addr_i == RA_DLEN);
  assign push_cmd_o = '{src: src_q, dst: dst_q, slen: slen_q, dlen: wdata_i};
  assign sts_o      = sts_q;
  assign irq_o      = |(sts_q & msk_q);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      RA_CTRL: rdata_o[1:0] = ctrl_q;
      RA_STAT: rdata_o[2:0] = {busy_i, q_empty_i, q_full_i};
      RA_ISTS: rdata_o[NUM_EV-1:0] = sts_q;
      RA_IMSK: rdata_o[NUM_EV-1:0] = msk_q;
      RA_SRC:  rdata_o = src_q;
      RA_DST:  rdata_o = dst_q;
      RA_SLEN: rdata_o = slen_q;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/cfg_dma_cmdq.sv
module cfg_dma_cmdq
  import cfg_dma_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     push_i,
  input  dma_cmd_t cmd_i,
  input  logic     pop_i,
  output dma_cmd_t head_o,
  output logic     full_o,
  output logic     empty_o,
  output logic     ovf_o
);
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  dma_cmd_t        slots [DEPTH];
  logic [PW-1:0]   wp_q, rp_q;
  logic [CW-1:0]   cnt_q;
  logic            wr_ok, rd_ok;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign wr_ok   = push_i && !full_o;
  assign rd_ok   = pop_i && !empty_o;
  assign ovf_o   = push_i && full_o;
  assign head_o  = slots[rp_q];

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (wr_ok) slots[wp_q] <= cmd_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_ok) wp_q <= nxt(wp_q);
      if (rd_ok) rp_q <= nxt(rp_q);
      case ({wr_ok, rd_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_seq.sv
module cfg_dma_seq
  import cfg_dma_pkg::*;
#(
  parameter int unsigned RD_TIMEOUT = 16,
  parameter int unsigned QGAP       = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  dma_cmd_t          head_i,
  input  logic              empty_i,
  output logic              pop_o,
  input  logic              loop_i,
  input  logic              qrate_i,
  output logic              mrd_req_o,
  output logic [WORD_W-1:0] mrd_addr_o,
  input  logic              mrd_gnt_i,
  input  logic              mrd_rvalid_i,
  input  logic [WORD_W-1:0] mrd_rdata_i,
  input  logic              mrd_err_i,
  output logic              mwr_valid_o,
  output logic [WORD_W-1:0] mwr_addr_o,
  output logic [WORD_W-1:0] mwr_data_o,
  input  logic              mwr_ready_i,
  input  logic              mwr_err_i,
  output logic              cfg_valid_o,
  output logic [WORD_W-1:0] cfg_data_o,
  input  logic              cfg_ready_i,
  output logic              busy_o,
  output logic [NUM_EV-1:0] evt_o
);
  localparam int unsigned TW = $clog2(RD_TIMEOUT + 1);
  localparam int unsigned GW = $clog2(QGAP + 1);

  seq_st_e           st_q;
  logic [WORD_W-1:0] src_q, dst_q, rem_q, data_q;
  logic              sink_q;
  logic [TW-1:0]     tmo_q;
  logic [GW-1:0]     gap_q;

  logic to_sink, len_bad, len_err, cmd_err, cfg_hs, wr_hs, beat_ok, tmo_hit, last;

  assign to_sink = (head_i.dst == SINK_ADDR) && !loop_i;
  assign len_bad = (head_i.slen != head_i.dlen);
  assign len_err = to_sink && len_bad;
  assign cmd_err = to_sink ? (!len_bad && head_i.slen == '0)
                           : (len_bad || head_i.slen == '0);

  assign pop_o       = (st_q == S_IDLE) && !empty_i;
  assign busy_o      = (st_q != S_IDLE);
  assign mrd_req_o   = (st_q == S_RD);
  assign mrd_addr_o  = src_q;
  assign mwr_valid_o = (st_q == S_XFER) && !sink_q;
  assign mwr_addr_o  = dst_q;
  assign mwr_data_o  = data_q;
  assign cfg_valid_o = (st_q == S_XFER) && sink_q && !(qrate_i && gap_q != '0);
  assign cfg_data_o  = data_q;

  assign cfg_hs  = cfg_valid_o && cfg_ready_i;
  assign wr_hs   = mwr_valid_o && mwr_ready_i;
  assign beat_ok = sink_q ? cfg_hs : (wr_hs && !mwr_err_i);
  assign tmo_hit = (st_q == S_WAIT) && !mrd_rvalid_i && (tmo_q == TW'(RD_TIMEOUT - 1));
  assign last    = (rem_q == WORD_W'(1));

  always_comb begin
    evt_o          = '0;
    evt_o[EV_DONE] = (st_q == S_XFER) && beat_ok && last;
    evt_o[EV_WERR] = wr_hs && mwr_err_i;
    evt_o[EV_RTO]  = tmo_hit;
    evt_o[EV_RERR] = (st_q == S_WAIT) && mrd_rvalid_i && mrd_err_i;
    evt_o[EV_RXOV] = mrd_rvalid_i && (st_q != S_WAIT);
    evt_o[EV_CMDE] = pop_o && cmd_err;
    evt_o[EV_LENE] = pop_o && len_err;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= S_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      rem_q  <= '0;
      data_q <= '0;
      sink_q <= 1'b0;
      tmo_q  <= '0;
      gap_q  <= '0;
    end else begin
      // spacing counter restarts on every sink acceptance
      if (cfg_hs)              gap_q <= GW'(QGAP);
      else if (gap_q != '0)    gap_q <= gap_q - 1'b1;
      case (st_q)
        S_IDLE: if (pop_o && !len_err && !cmd_err) begin
          src_q  <= head_i.src;
          dst_q  <= head_i.dst;
          rem_q  <= head_i.slen;
          sink_q <= to_sink;
          st_q   <= S_RD;
        end
        S_RD: if (mrd_gnt_i) begin
          tmo_q <= '0;
          st_q  <= S_WAIT;
        end
        S_WAIT: begin
          if (mrd_rvalid_i) begin
            data_q <= mrd_rdata_i;
            st_q   <= mrd_err_i ? S_IDLE : S_XFER;
          end else if (tmo_hit) begin
            st_q <= S_IDLE;
          end else begin
            tmo_q <= tmo_q + 1'b1;
          end
        end
        S_XFER: begin
          if (wr_hs && mwr_err_i) begin
            st_q <= S_IDLE;
          end else if (beat_ok) begin
            rem_q <= rem_q - 1'b1;
            src_q <= src_q + WORD_W'(4);
            dst_q <= dst_q + WORD_W'(4);
            st_q  <= last ? S_IDLE : S_RD;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfg_dma_top.sv
module cfg_dma_top
  import cfg_dma_pkg::*;
#(
  parameter int unsigned Q_DEPTH    = 4,
  parameter int unsigned RD_TIMEOUT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [WORD_W-1:0] reg_wdata_i,
  output logic [WORD_W-1:0] reg_rdata_o,
  output logic              irq_o,
  output logic              mrd_req_o,
  output logic [WORD_W-1:0] mrd_addr_o,
  input  logic              mrd_gnt_i,
  input  logic              mrd_rvalid_i,
  input  logic [WORD_W-1:0] mrd_rdata_i,
  input  logic              mrd_err_i,
  output logic              mwr_valid_o,
  output logic [WORD_W-1:0] mwr_addr_o,
  output logic [WORD_W-1:0] mwr_data_o,
  input  logic              mwr_ready_i,
  input  logic              mwr_err_i,
  output logic              cfg_valid_o,
  output logic [WORD_W-1:0] cfg_data_o,
  input  logic              cfg_ready_i
);
  logic              ctrl_loop, ctrl_qrate;
  logic              q_push, q_pop, q_full, q_empty, q_ovf, seq_busy;
  dma_cmd_t          push_cmd, q_head;
  logic [NUM_EV-1:0] seq_evt, evt_all, int_sts;

  always_comb begin
    evt_all         = seq_evt;
    evt_all[EV_QOV] = q_ovf;
  end

  cfg_dma_regs u_regs (
    .clk_i, .rst_ni,
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .loop_o     (ctrl_loop),
    .qrate_o    (ctrl_qrate),
    .push_o     (q_push),
    .push_cmd_o (push_cmd),
    .q_full_i   (q_full),
    .q_empty_i  (q_empty),
    .busy_i     (seq_busy),
    .evt_i      (evt_all),
    .sts_o      (int_sts),
    .irq_o      (irq_o)
  );

  cfg_dma_cmdq #(.DEPTH(Q_DEPTH)) u_cmdq (
    .clk_i, .rst_ni,
    .push_i  (q_push),
    .cmd_i   (push_cmd),
    .pop_i   (q_pop),
    .head_o  (q_head),
    .full_o  (q_full),
    .empty_o (q_empty),
    .ovf_o   (q_ovf)
  );

  cfg_dma_seq #(.RD_TIMEOUT(RD_TIMEOUT)) u_seq (
    .clk_i, .rst_ni,
    .head_i       (q_head),
    .empty_i      (q_empty),
    .pop_o        (q_pop),
    .loop_i       (ctrl_loop),
    .qrate_i      (ctrl_qrate),
    .mrd_req_o, .mrd_addr_o, .mrd_gnt_i, .mrd_rvalid_i, .mrd_rdata_i, .mrd_err_i,
    .mwr_valid_o, .mwr_addr_o, .mwr_data_o, .mwr_ready_i, .mwr_err_i,
    .cfg_valid_o, .cfg_data_o, .cfg_ready_i,
    .busy_o       (seq_busy),
    .evt_o        (seq_evt)
  );
endmodule

// File: rtl/cfg_dma_chk.sv
module cfg_dma_chk
  import cfg_dma_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_valid_i,
  input logic              cfg_ready_i,
  input logic [WORD_W-1:0] cfg_data_i,
  input logic              mwr_valid_i,
  input logic              mrd_req_i,
  input logic              qrate_i,
  input logic              q_full_i,
  input logic              q_push_i,
  input logic [NUM_EV-1:0] sts_i,
  input logic [NUM_EV-1:0] evt_i
);
  logic hs;
  assign hs = cfg_valid_i && cfg_ready_i;

  a_r6_quarter_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hs && qrate_i) |-> (!$past(hs, 1) && !$past(hs, 2) && !$past(hs, 3)));

  a_r3_sink_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_valid_i && !cfg_ready_i) |=> ($stable(cfg_data_i) && (cfg_valid_i || $rose(qrate_i))));

  a_r2_overflow_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q_full_i && q_push_i) |=> sts_i[EV_QOV]);

  a_r13_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i[EV_DONE] |=> sts_i[EV_DONE]);

  a_r5_one_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cfg_valid_i && mwr_valid_i));

  a_r10_read_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mrd_req_i |-> (!cfg_valid_i && !mwr_valid_i));
endmodule

bind cfg_dma_top cfg_dma_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_valid_i (cfg_valid_o),
  .cfg_ready_i (cfg_ready_i),
  .cfg_data_i  (cfg_data_o),
  .mwr_valid_i (mwr_valid_o),
  .mrd_req_i   (mrd_req_o),
  .qrate_i     (ctrl_qrate),
  .q_full_i    (q_full),
  .q_push_i    (q_push),
  .sts_i       (int_sts),
  .evt_i       (evt_all)
);

// File: tb/cfg_dma_top_bench.sv
module cfg_dma_top_bench;
  import cfg_dma_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o;
  logic        mrd_req_o;
  logic [31:0] mrd_addr_o;
  logic        mrd_gnt_i;
  logic        mrd_rvalid_i;
  logic [31:0] mrd_rdata_i;
  logic        mrd_err_i;
  logic        mwr_valid_o;
  logic [31:0] mwr_addr_o;
  logic [31:0] mwr_data_o;
  logic        mwr_ready_i;
  logic        mwr_err_i;
  logic        cfg_valid_o;
  logic [31:0] cfg_data_o;
  logic        cfg_ready_i = 1'b1;

  logic        mem_silent = 1'b0, mem_err = 1'b0, wr_err = 1'b0, inject = 1'b0;
  logic        rv_q = 1'b0, re_q = 1'b0;
  logic [31:0] rd_q = '0;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit done_flag = 0;

  logic [31:0] snk_d [64];
  int          snk_c [64];
  int          snk_n = 0;
  logic [31:0] wr_a [64];
  logic [31:0] wr_d [64];
  int          wr_n = 0;

  always #5 clk_i = ~clk_i;

  cfg_dma_top u_cfg_dma_top (.*);

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C3C, a[31:16]};
  endfunction

  assign mrd_gnt_i    = 1'b1;
  assign mwr_ready_i  = 1'b1;
  assign mwr_err_i    = wr_err;
  assign mrd_rvalid_i = rv_q | inject;
  assign mrd_rdata_i  = rd_q;
  assign mrd_err_i    = re_q & rv_q;

  always @(posedge clk_i) begin
    cyc  <= cyc + 1;
    rv_q <= mrd_req_o && mrd_gnt_i && !mem_silent;
    rd_q <= pat(mrd_addr_o);
    re_q <= mem_err;
    if (cfg_valid_o && cfg_ready_i && snk_n < 64) begin
      snk_d[snk_n] <= cfg_data_o;
      snk_c[snk_n] <= cyc;
      snk_n <= snk_n + 1;
    end
    if (mwr_valid_o && mwr_ready_i && wr_n < 64) begin
      wr_a[wr_n] <= mwr_addr_o;
      wr_d[wr_n] <= mwr_data_o;
      wr_n <= wr_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk_i);
    reg_addr_i = a;
    #1 v = reg_rdata_o;
  endtask

  task automatic push(input logic [31:0] s, d, sl, dl);
    wr(RA_SRC, s); wr(RA_DST, d); wr(RA_SLEN, sl); wr(RA_DLEN, dl);
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 400; i++) begin
      rd(RA_STAT, v);
      if (v[2] == 1'b0 && v[1] == 1'b1) break;
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(RA_STAT, v);  check(v[2:0] == 3'b010, "R2 reset status", v, 32'h2);
    rd(RA_ISTS, v);  check(v == 0, "R13 reset int status", v, 0);
    check(irq_o == 1'b0 && cfg_valid_o == 1'b0, "R14 reset outputs", {irq_o, cfg_valid_o}, 0);
  endtask

  task automatic t_sink();
    logic [31:0] v; int b = snk_n;
    wr(RA_ISTS, 32'hFF);
    wr(RA_SRC, 32'h100); wr(RA_DST, SINK_ADDR); wr(RA_SLEN, 4);
    rd(RA_STAT, v);  check(v[1] == 1'b1 && v[2] == 1'b0, "R1 no push before count", v, 32'h2);
    wr(RA_DLEN, 4);
    wait_idle();
    check(snk_n - b == 4, "R3 sink word count", snk_n - b, 4);
    for (int k = 0; k < 4; k++)
      check(snk_d[b+k] == pat(32'h100 + 4*k), "R3 sink data", snk_d[b+k], pat(32'h100 + 4*k));
    check(snk_c[b+1] - snk_c[b] == 3, "R6 full-rate spacing", snk_c[b+1] - snk_c[b], 3);
    rd(RA_ISTS, v);  check(v == 32'h1, "R7 done set", v, 1);
  endtask

  task automatic t_quarter();
    int b = snk_n;
    wr(RA_CTRL, 32'h2);
    push(32'h200, SINK_ADDR, 3, 3);
    wait_idle();
    check(snk_n - b == 3, "R6 quarter count", snk_n - b, 3);
    for (int k = 1; k < 3; k++)
      check(snk_c[b+k] - snk_c[b+k-1] == 4, "R6 quarter spacing", snk_c[b+k] - snk_c[b+k-1], 4);
    wr(RA_CTRL, 0);
  endtask

  task automatic t_loopback();
    int bs = snk_n, bw = wr_n;
    wr(RA_CTRL, 32'h1);
    push(32'h300, SINK_ADDR, 2, 2);
    wait_idle();
    check(snk_n == bs, "R5 sink idle in loopback", snk_n - bs, 0);
    check(wr_n - bw == 2, "R5 loopback writes", wr_n - bw, 2);
    check(wr_d[bw+1] == pat(32'h304), "R5 loopback data", wr_d[bw+1], pat(32'h304));
    wr(RA_CTRL, 0);
  endtask

  task automatic t_memdst();
    int bw = wr_n;
    push(32'h400, 32'h8000, 3, 3);
    wait_idle();
    check(wr_n - bw == 3, "R4 memory write count", wr_n - bw, 3);
    for (int k = 0; k < 3; k++) begin
      check(wr_a[bw+k] == 32'h8000 + 4*k, "R4 write address", wr_a[bw+k], 32'h8000 + 4*k);
      check(wr_d[bw+k] == pat(32'h400 + 4*k), "R4 write data", wr_d[bw+k], pat(32'h400 + 4*k));
    end
  endtask

  task automatic t_errors_cmd();
    logic [31:0] v; int bs = snk_n, bw = wr_n;
    wr(RA_ISTS, 32'hFF);
    push(32'h500, SINK_ADDR, 2, 3);
    wait_idle();
    rd(RA_ISTS, v);  check(v == 32'h80, "R8 length error", v, 32'h80);
    check(snk_n == bs, "R8 not executed", snk_n - bs, 0);
    wr(RA_ISTS, 32'hFF);
    push(32'h500, 32'h9000, 0, 0);
    wait_idle();
    rd(RA_ISTS, v);  check(v == 32'h20, "R9 zero count", v, 32'h20);
    wr(RA_ISTS, 32'hFF);
    push(32'h500, 32'h9000, 2, 1);
    wait_idle();
    rd(RA_ISTS, v);  check(v == 32'h20, "R9 unequal memory counts", v, 32'h20);
    check(wr_n == bw, "R9 not executed", wr_n - bw, 0);
  endtask

  task automatic t_read_errs();
    logic [31:0] v; int bs = snk_n;
    wr(RA_ISTS, 32'hFF);
    mem_err = 1'b1;
    push(32'h600, SINK_ADDR, 2, 2);
    wait_idle();
    mem_err = 1'b0;
    rd(RA_ISTS, v);  check(v == 32'h08, "R10 read error", v, 32'h08);
    wr(RA_ISTS, 32'hFF);
    mem_silent = 1'b1;
    push(32'h600, SINK_ADDR, 1, 1);
    wait_idle();
    mem_silent = 1'b0;
    rd(RA_ISTS, v);  check(v == 32'h04, "R10 read timeout", v, 32'h04);
    check(snk_n == bs, "R10 nothing delivered", snk_n - bs, 0);
  endtask

  task automatic t_write_err();
    logic [31:0] v; int bw = wr_n;
    wr(RA_ISTS, 32'hFF);
    wr_err = 1'b1;
    push(32'h700, 32'hA000, 3, 3);
    wait_idle();
    wr_err = 1'b0;
    rd(RA_ISTS, v);  check(v == 32'h02, "R11 write error", v, 32'h02);
    check(wr_n - bw == 1, "R11 aborted after one", wr_n - bw, 1);
  endtask

  task automatic t_rxovf();
    logic [31:0] v;
    wr(RA_ISTS, 32'hFF);
    @(negedge clk_i); inject = 1'b1;
    @(negedge clk_i); inject = 1'b0;
    rd(RA_ISTS, v);  check(v == 32'h10, "R12 receive overflow", v, 32'h10);
  endtask

  task automatic t_collide();
    logic [31:0] v; int b;
    wr(RA_ISTS, 32'hFF);
    push(32'h800, SINK_ADDR, 1, 1);
    wait_idle();
    rd(RA_ISTS, v);  check(v[0] == 1'b1, "R7 done before collision", v, 1);
    wr(RA_ISTS, 32'h0);
    rd(RA_ISTS, v);  check(v[0] == 1'b1, "R13 zero write no effect", v, 1);
    cfg_ready_i = 1'b0;
    push(32'h900, SINK_ADDR, 1, 1);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk_i);
      if (cfg_valid_o) break;
    end
    b = snk_n;
    reg_we_i = 1'b1; reg_addr_i = RA_ISTS; reg_wdata_i = 32'h1; cfg_ready_i = 1'b1;
    @(negedge clk_i);
    reg_we_i = 1'b0;
    check(snk_n - b == 1, "R13 word taken in clear cycle", snk_n - b, 1);
    rd(RA_ISTS, v);  check(v[0] == 1'b1, "R13 set wins over clear", v, 1);
    wr(RA_ISTS, 32'h1);
    rd(RA_ISTS, v);  check(v[0] == 1'b0, "R13 clear by one", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(RA_ISTS, 32'hFF);
    push(32'hA00, SINK_ADDR, 1, 1);
    wait_idle();
    wr(RA_IMSK, 32'h0);  #1 check(irq_o == 1'b0, "R14 masked off", irq_o, 0);
    wr(RA_IMSK, 32'h2);  #1 check(irq_o == 1'b0, "R14 other bit enabled", irq_o, 0);
    wr(RA_IMSK, 32'h1);  #1 check(irq_o == 1'b1, "R14 enabled", irq_o, 1);
    wr(RA_ISTS, 32'h1);  #1 check(irq_o == 1'b0, "R14 after clear", irq_o, 0);
    wr(RA_IMSK, 32'h0);
    rd(RA_STAT, v);
  endtask

  task automatic t_queue();
    logic [31:0] v; int b = snk_n;
    wr(RA_ISTS, 32'hFF);
    cfg_ready_i = 1'b0;
    push(32'hB00, SINK_ADDR, 1, 1);
    repeat (6) @(negedge clk_i);
    for (int k = 1; k < 5; k++) push(32'hB00 + 32'h10*k, SINK_ADDR, 1, 1);
    rd(RA_STAT, v);  check(v[0] == 1'b1, "R2 full after four queued", v, 1);
    rd(RA_ISTS, v);  check(v[6] == 1'b0, "R2 no overflow yet", v, 0);
    push(32'hF00, SINK_ADDR, 1, 1);
    rd(RA_ISTS, v);  check(v[6] == 1'b1, "R2 overflow flagged", v, 32'h40);
    cfg_ready_i = 1'b1;
    wait_idle();
    check(snk_n - b == 5, "R2 dropped command absent", snk_n - b, 5);
    check(snk_d[b+4] == pat(32'hB40), "R2 last kept command", snk_d[b+4], pat(32'hB40));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_sink();
    t_quarter();
    t_loopback();
    t_memdst();
    t_errors_cmd();
    t_read_errs();
    t_write_err();
    t_rxovf();
    t_collide();
    t_irq();
    t_queue();
    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule